// File: doc/BRIEF.md
# Dataflow Token Flit Deframer

This block sits on the receive side of a network link that feeds a dataflow processing element. Flits are 16 bits wide and arrive one per cycle over a valid/ready handshake. The first flit of each packet is a header. A short prefix code at its top decides what kind of token the packet carries. That code also decides whether one data flit follows the header or whether the header is the whole packet.

The deframer takes the header apart into named fields. When a data flit is due, it holds those fields until the data flit arrives. It then places the complete token in an output register with its own valid/ready handshake. While a finished token waits for a consumer that is not ready, the flit input is stalled. Tokens therefore are never dropped or overwritten.

Top module: `token_deframer`

## Requirements
- R1: A synchronous active-high reset clears `tok_valid` and leaves the block expecting a header, so `flit_ready` is 1 in the first cycle after reset.
- R2: A header with bit 15 = 1 is a memory token of two flits. It is presented with kind 0, target = bits [14:13], op = bits [12:10], offset = bits [9:0], act 0, port 0, and data = the second flit.
- R3: A header with bits [15:14] = 00 is a dyadic token of two flits. It is presented with kind 1, port = bit 13, target = bits [12:11], offset = bits [10:3], act = bits [2:0], op 0, and data = the second flit.
- R4: A header with bits [15:13] = 010 is a normal monadic token of two flits. It is presented with kind 2, port 0, target = bits [12:11], offset = bits [10:3], act = bits [2:0], op 0, and data = the second flit.
- R5: A header with bits [15:13] = 011 and bits [10:9] = 10 is an inline monadic token of one flit. It is presented with kind 3, target = bits [12:11], offset = bits [8:2], and act, port, op and data all 0. Bits [1:0] are ignored.
- R6: A header with bits [15:13] = 011 and bits [10:9] other than 10 is a control token of two flits. It is presented with kind 4, target = bits [12:11], op = {0, bits [10:9]}, offset = bits [8:0], act 0, port 0, and data = the second flit.
- R7: `tok_valid` rises in the cycle after the packet's last flit is accepted. Accepting only the header of a two-flit packet produces no token.
- R8: `flit_ready` is 0 exactly while `tok_valid` is 1 and `tok_ready` is 0. During that time every token output holds its value.
- R9: A token leaves on an edge where `tok_valid` and `tok_ready` are both 1. `tok_valid` is then 0 in the next cycle, unless a packet completes on that same edge; in that case the new token is presented with no gap.
- R10: A reset asserted after a header but before its data flit discards the partial packet, so the next accepted flit is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_valid | input | 1 | Incoming flit is valid |
| flit_ready | output | 1 | Block can accept a flit this cycle |
| flit_data | input | 16 | Incoming flit |
| tok_valid | output | 1 | A decoded token is presented |
| tok_ready | input | 1 | Consumer takes the token |
| tok_kind | output | 3 | 0 memory, 1 dyadic, 2 monadic, 3 inline, 4 control |
| tok_target | output | 2 | Target PE or memory-unit id |
| tok_offset | output | 10 | Offset or memory address, zero-extended |
| tok_act | output | 3 | Activation id |
| tok_port | output | 1 | Operand port (1 = right) |
| tok_op | output | 3 | Memory op or control subcode |
| tok_data | output | 16 | Data flit, 0 for inline tokens |

## Verification
The bench goes after the prefix boundaries. An inline header whose spare bits are set must still end after one flit. A 011 header with another subcode must wait for data. A design that decoded only three prefix bits would swallow the next header as data, or emit a control token early. Under back-pressure, a flit offered while the output is full must not be taken; a wrong design would overwrite or lose the held token. The release edge must hand off and reload in one cycle. A reset in the middle of a packet must not leave the block waiting for a data flit, or the next header would come out as memory data.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

    localparam int FLIT_W = 16;
    localparam int TGT_W  = 2;
    localparam int OFS_W  = 10;
    localparam int ACT_W  = 3;
    localparam int OP_W   = 3;
    localparam int KIND_W = 3;

    // header sub-field positions that the prefix decode depends on
    localparam int MSB      = FLIT_W - 1;
    localparam int SUB_HI   = 10;
    localparam int SUB_LO   = 9;
    localparam logic [1:0] INLINE_SUB = 2'b10;

    typedef enum logic [KIND_W-1:0] {
        TK_MEM    = 3'd0,
        TK_DYAD   = 3'd1,
        TK_MONAD  = 3'd2,
        TK_INLINE = 3'd3,
        TK_CTRL   = 3'd4
    } tok_kind_e;

    typedef struct packed {
        tok_kind_e             kind;
        logic [TGT_W-1:0]      target;
        logic [OFS_W-1:0]      offset;
        logic [ACT_W-1:0]      act;
        logic                  port;
        logic [OP_W-1:0]       op;
        logic [FLIT_W-1:0]     data;
    } token_t;

    // Variable-length prefix: 1 / 00 / 010 / 011+subcode
    function automatic tok_kind_e classify(input logic [FLIT_W-1:0] h);
        tok_kind_e k;
        if (h[MSB])
            k = TK_MEM;
        else if (!h[MSB-1])
            k = TK_DYAD;
        else if (!h[MSB-2])
            k = TK_MONAD;
        else if (h[SUB_HI:SUB_LO] == INLINE_SUB)
            k = TK_INLINE;
        else
            k = TK_CTRL;
        return k;
    endfunction

    function automatic logic is_single(input tok_kind_e k);
        return (k == TK_INLINE);
    endfunction

    function automatic token_t decode_header(input logic [FLIT_W-1:0] h);
        token_t t;
        t        = '0;
        t.kind   = classify(h);
        t.target = h[12:11];
        unique case (t.kind)
            TK_MEM: begin
                t.target = h[14:13];
                t.op     = h[12:10];
                t.offset = h[9:0];
            end
            TK_DYAD: begin
                t.port   = h[13];
                t.offset = {2'b00, h[10:3]};
                t.act    = h[2:0];
            end
            TK_MONAD: begin
                t.offset = {2'b00, h[10:3]};
                t.act    = h[2:0];
            end
            TK_INLINE: begin
                t.offset = {3'b000, h[8:2]};
            end
            default: begin
                t.op     = {1'b0, h[10:9]};
                t.offset = {1'b0, h[8:0]};
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/df_header_decode.sv
module df_header_decode
    import deframer_pkg::*;
(
    input  logic [FLIT_W-1:0] flit,
    output token_t            hdr_tok,
    output logic              hdr_single
);
    always_comb begin
        hdr_tok    = decode_header(flit);
        hdr_single = is_single(hdr_tok.kind);
    end
endmodule

// File: rtl/df_seq.sv
module df_seq
    import deframer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [FLIT_W-1:0] flit,
    input  token_t            hdr_tok,
    input  logic              hdr_single,
    output logic              load,
    output token_t            load_tok
);
    typedef enum logic {ST_HEADER = 1'b0, ST_DATA = 1'b1} st_e;

    st_e    state_q;
    token_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HEADER;
            pend_q  <= '0;
        end else if (accept) begin
            if (state_q == ST_HEADER) begin
                if (!hdr_single) begin
                    pend_q  <= hdr_tok;
                    state_q <= ST_DATA;
                end
            end else begin
                state_q <= ST_HEADER;
            end
        end
    end

    always_comb begin
        load     = 1'b0;
        load_tok = hdr_tok;
        if (accept) begin
            if (state_q == ST_HEADER) begin
                load = hdr_single;
            end else begin
                load          = 1'b1;
                load_tok      = pend_q;
                load_tok.data = flit;
            end
        end
    end
endmodule

// File: rtl/df_out_reg.sv
module df_out_reg
    import deframer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  token_t load_tok,
    input  logic   out_ready,
    output logic   out_valid,
    output token_t out_tok,
    output logic   can_take
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tok   <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_tok   <= load_tok;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign can_take = !out_valid || out_ready;
endmodule

// File: rtl/token_deframer.sv
module token_deframer
    import deframer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flit_valid,
    output logic              flit_ready,
    input  logic [FLIT_W-1:0] flit_data,
    output logic              tok_valid,
    input  logic              tok_ready,
    output logic [KIND_W-1:0] tok_kind,
    output logic [TGT_W-1:0]  tok_target,
    output logic [OFS_W-1:0]  tok_offset,
    output logic [ACT_W-1:0]  tok_act,
    output logic              tok_port,
    output logic [OP_W-1:0]   tok_op,
    output logic [FLIT_W-1:0] tok_data
);
    token_t hdr_tok, load_tok, out_tok;
    logic   hdr_single, load, accept, can_take;

    assign accept     = flit_valid && can_take;
    assign flit_ready = can_take;

    df_header_decode u_dec (
        .flit       (flit_data),
        .hdr_tok    (hdr_tok),
        .hdr_single (hdr_single)
    );

    df_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .flit       (flit_data),
        .hdr_tok    (hdr_tok),
        .hdr_single (hdr_single),
        .load       (load),
        .load_tok   (load_tok)
    );

    df_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_tok  (load_tok),
        .out_ready (tok_ready),
        .out_valid (tok_valid),
        .out_tok   (out_tok),
        .can_take  (can_take)
    );

    assign tok_kind   = out_tok.kind;
    assign tok_target = out_tok.target;
    assign tok_offset = out_tok.offset;
    assign tok_act    = out_tok.act;
    assign tok_port   = out_tok.port;
    assign tok_op     = out_tok.op;
    assign tok_data   = out_tok.data;
endmodule

// File: rtl/df_checker.sv
module df_checker
    import deframer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              flit_valid,
    input logic              flit_ready,
    input logic              tok_valid,
    input logic              tok_ready,
    input logic [KIND_W-1:0] tok_kind,
    input logic [TGT_W-1:0]  tok_target,
    input logic [OFS_W-1:0]  tok_offset,
    input logic [ACT_W-1:0]  tok_act,
    input logic              tok_port,
    input logic [OP_W-1:0]   tok_op,
    input logic [FLIT_W-1:0] tok_data
);
    logic prev_rst_q;
    always_ff @(posedge clk) prev_rst_q <= rst;

    // R1: output empty right after reset
    always @(posedge clk) begin
        if (prev_rst_q === 1'b1)
            p_reset_empty_r1: assert (!tok_valid && flit_ready);
    end

    p_mem_fields_r2: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_kind == TK_MEM) |-> (tok_act == '0 && !tok_port));

    p_inline_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_kind == TK_INLINE)
            |-> (tok_data == '0 && tok_act == '0 && tok_op == '0 && !tok_port));

    p_kind_legal_r7: assert property (@(posedge clk) disable iff (rst)
        tok_valid |-> (tok_kind <= TK_CTRL));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_kind)
            && $stable(tok_target) && $stable(tok_offset) && $stable(tok_act)
            && $stable(tok_port) && $stable(tok_op) && $stable(tok_data)));

    p_no_stall_empty_r8: assert property (@(posedge clk) disable iff (rst)
        !tok_valid |-> flit_ready);

    p_drain_r9: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_ready && !(flit_valid && flit_ready)) |=> !tok_valid);
endmodule

bind token_deframer df_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .flit_valid (flit_valid),
    .flit_ready (flit_ready),
    .tok_valid  (tok_valid),
    .tok_ready  (tok_ready),
    .tok_kind   (tok_kind),
    .tok_target (tok_target),
    .tok_offset (tok_offset),
    .tok_act    (tok_act),
    .tok_port   (tok_port),
    .tok_op     (tok_op),
    .tok_data   (tok_data)
);

// File: tb/tb_token_deframer.sv
module tb_token_deframer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flit_valid = 1'b0;
    logic        flit_ready;
    logic [15:0] flit_data = '0;
    logic        tok_valid;
    logic        tok_ready = 1'b1;
    logic [2:0]  tok_kind;
    logic [1:0]  tok_target;
    logic [9:0]  tok_offset;
    logic [2:0]  tok_act;
    logic        tok_port;
    logic [2:0]  tok_op;
    logic [15:0] tok_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    token_deframer dut (.*);

    typedef struct packed {
        logic [15:0] f0;
        logic [15:0] f1;
        logic        two;
        logic [2:0]  kind;
        logic [1:0]  tgt;
        logic [9:0]  off;
        logic [2:0]  act;
        logic        port;
        logic [2:0]  op;
        logic [15:0] data;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'hD6A7, 16'hBEEF, 1'b1, 3'd0, 2'd2, 10'h2A7, 3'd0, 1'b0, 3'd5, 16'hBEEF}, // R2
        '{16'hFFFF, 16'h0001, 1'b1, 3'd0, 2'd3, 10'h3FF, 3'd0, 1'b0, 3'd7, 16'h0001}, // R2
        '{16'h2E2E, 16'h1234, 1'b1, 3'd1, 2'd1, 10'h0C5, 3'd6, 1'b1, 3'd0, 16'h1234}, // R3
        '{16'h1FFF, 16'hFFFF, 1'b1, 3'd1, 2'd3, 10'h0FF, 3'd7, 1'b0, 3'd0, 16'hFFFF}, // R3
        '{16'h51E1, 16'h5555, 1'b1, 3'd2, 2'd2, 10'h03C, 3'd1, 1'b0, 3'd0, 16'h5555}, // R4
        '{16'h6D54, 16'h0000, 1'b0, 3'd3, 2'd1, 10'h055, 3'd0, 1'b0, 3'd0, 16'h0000}, // R5
        '{16'h65FF, 16'h0000, 1'b0, 3'd3, 2'd0, 10'h07F, 3'd0, 1'b0, 3'd0, 16'h0000}, // R5
        '{16'h7BA5, 16'hCAFE, 1'b1, 3'd4, 2'd3, 10'h1A5, 3'd0, 1'b0, 3'd1, 16'hCAFE}, // R6
        '{16'h6600, 16'h0F0F, 1'b1, 3'd4, 2'd0, 10'h000, 3'd0, 1'b0, 3'd3, 16'h0F0F}  // R6
    };

    function automatic logic [37:0] exp_fields(input vec_t v);
        return {v.kind, v.tgt, v.off, v.act, v.port, v.op, v.data};
    endfunction

    function automatic logic [37:0] act_fields();
        return {tok_kind, tok_target, tok_offset, tok_act, tok_port, tok_op, tok_data};
    endfunction

    task automatic check(input string req, input logic [63:0] actual, input logic [63:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, actual, expected);
        end
    endtask

    // Drives a flit from a negedge, waits for acceptance, returns at the next negedge.
    task automatic send(input logic [15:0] f);
        @(negedge clk);
        flit_valid = 1'b1;
        flit_data  = f;
        while (!flit_ready) @(negedge clk);
        @(negedge clk);
        flit_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", {62'd0, tok_valid, flit_ready}, 64'd1);

        // table walk, consumer always ready
        for (int i = 0; i < NV; i++) begin
            send(VECS[i].f0);
            if (VECS[i].two) begin
                check("R7 no token after header", {63'd0, tok_valid}, 64'd0);
                send(VECS[i].f1);
            end
            check("R7 token valid", {63'd0, tok_valid}, 64'd1);
            check($sformatf("R2-6 vec%0d fields", i), {26'd0, act_fields()}, {26'd0, exp_fields(VECS[i])});
        end

        // R9: drains when nothing new arrives
        @(negedge clk);
        check("R9 drain", {63'd0, tok_valid}, 64'd0);

        // R8: back-pressure
        tok_ready = 1'b0;
        send(VECS[5].f0);
        check("R8 stall", {62'd0, tok_valid, flit_ready}, 64'd2);
        flit_valid = 1'b1;
        flit_data  = VECS[6].f0;
        repeat (3) @(negedge clk);
        check("R8 held token", {25'd0, tok_valid, act_fields()}, {25'd0, 1'b1, exp_fields(VECS[5])});
        check("R8 still stalled", {63'd0, flit_ready}, 64'd0);

        // R9: release hands off and reloads in one edge
        tok_ready = 1'b1;
        @(negedge clk);
        flit_valid = 1'b0;
        check("R9 back-to-back", {25'd0, tok_valid, act_fields()}, {25'd0, 1'b1, exp_fields(VECS[6])});
        @(negedge clk);
        check("R9 drain after handoff", {63'd0, tok_valid}, 64'd0);

        // R10: reset mid-packet
        send(VECS[0].f0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-run", {62'd0, tok_valid, flit_ready}, 64'd1);
        send(VECS[5].f0);
        check("R10 header after reset", {25'd0, tok_valid, act_fields()}, {25'd0, 1'b1, exp_fields(VECS[5])});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule